// File: doc/BRIEF.md
# Configurable Protocol Frame Filter

This block watches a byte-wide stream of received passive-optical-network frames. Each frame is marked by start and end strobes. Control frames and maintenance frames are recognised by their Ethernet type. Frames that belong to the registration exchange always pass. Every other control or maintenance frame passes only if it meets user rules, and all remaining traffic is dropped.

The user rules are built from two terms. The first is a table of 64 link identifiers, each entry with its own valid bit. The second is a pair of 6-byte keyword matchers with per-bit masks, and each matcher may be placed anywhere in the first 64 bytes of the frame. A mode field selects either term alone, or their AND, or their OR.

The stream leaves the block one cycle after it enters, with a keep flag raised on the end-of-frame beat. Downstream capture logic stores or discards the frame based on that flag. Configuration is written through a single-cycle register write port. A write is made only while no frame is in flight.

Top module: `pon_frame_filter`

## Requirements
- R1: A frame can pass only if its type field (byte 20 as the high octet, byte 21 as the low octet; byte 0 is the beat carrying the start strobe) equals 0x8808 (control) or 0x8809 (maintenance). Any other type, and any frame shorter than 22 bytes, is dropped.
- R2: A control frame (type 0x8808) of at least 24 bytes is kept whatever the rules say if its opcode (bytes 22 and 23) is 0x0004, 0x0005 or 0x0006, or if its opcode is 0x0002 and its link identifier is 0x7FFF. A maintenance frame gets no such bypass.
- R3: The link identifier is the low 15 bits of the 16-bit field at bytes 6 (high) and 7 (low); bit 15 is ignored. The identifier term is true when any valid table entry holds that identifier.
- R4: When the table holds no valid entry, or none that matches, the identifier term is false.
- R5: Keyword set k compares frame bytes off..off+5 with value byte j (bits 8j+7..8j) under mask byte j. Only bits whose mask bit is 1 take part. The keyword term is the OR of the enabled sets.
- R6: A keyword set does not match if the frame ends before byte off+5. A set whose offset is above 58 never matches.
- R7: The mode selects the user term: 0 takes the identifier term, 1 the keyword term, 2 their AND, 3 their OR.
- R8: The output stream repeats the input beats one cycle later, and its bytes and strobes are unchanged. The keep flag is valid only on the output end-of-frame beat and is low on every other beat.
- R9: Configuration map (the low 8 bits of the write address):
  - 0x00 to 0x3F: table entry (data bit 15 = valid, bits 14..0 = identifier).
  - 0x40: mode (bits 1..0).
  - For set k, at 0x50+8k: value bytes 0..3; at +1: value bytes 4..5 in bits 15..0; at +2 and +3: mask, laid out the same way; at +4: enable in bit 8 and offset in bits 5..0.
  - Writes to other addresses change nothing.
  - Reset clears all valid bits, sets mode 0 and disables both keyword sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input beat carries a byte |
| inSof | input | 1 | First byte of a frame (with inValid) |
| inEof | input | 1 | Last byte of a frame (with inValid) |
| inByte | input | 8 | Frame byte |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| outValid | output | 1 | Delayed beat valid |
| outSof | output | 1 | Delayed start strobe |
| outEof | output | 1 | Delayed end strobe |
| outByte | output | 8 | Delayed frame byte |
| outKeep | output | 1 | Keep decision, valid on the outEof beat |

## Verification
The assertions assume that the input stream is well formed. That means each start strobe is followed by exactly one end strobe before the next frame begins, no strobe appears on an idle beat, and configuration writes happen only between frames. The stimulus follows these rules. Frames are sent one at a time, sometimes with idle beats inside them. Every rule change is applied after the previous frame's last beat. Random frames are biased toward table identifiers and toward keywords planted at the configured offset, so that both terms are hit often.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int IDX_W   = 7;
  localparam int LLID_W  = 15;
  localparam int LLID_HI = 6;
  localparam int LLID_LO = 7;
  localparam int TYPE_LO = 21;
  localparam int OP_LO   = 23;
  localparam logic [15:0] TYPE_CTL = 16'h8808;
  localparam logic [15:0] TYPE_OAM = 16'h8809;
  localparam logic [LLID_W-1:0] LLID_BCAST = 15'h7FFF;

  typedef enum logic [1:0] {
    MODE_LLID = 2'd0,
    MODE_KW   = 2'd1,
    MODE_AND  = 2'd2,
    MODE_OR   = 2'd3
  } pfMode_e;

  typedef struct packed {
    logic             beat;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
    logic             capLlid;
    logic             capType;
    logic             capOp;
  } pfStrobe_t;
endpackage

// File: rtl/pff_cfg_regs.sv
module pff_cfg_regs
  import pf_pkg::*;
#(
  parameter int LLID_N   = 64,
  parameter int KW_SETS  = 2,
  parameter int KW_BYTES = 6,
  parameter int OFF_W    = 6
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgWe,
  input  logic [7:0]                           cfgAddr,
  input  logic [31:0]                          cfgData,
  output logic [LLID_N-1:0]                    tabValid,
  output logic [LLID_N-1:0][LLID_W-1:0]        tabLlid,
  output pfMode_e                              modeReg,
  output logic [KW_SETS-1:0][KW_BYTES*8-1:0]   kwVal,
  output logic [KW_SETS-1:0][KW_BYTES*8-1:0]   kwMask,
  output logic [KW_SETS-1:0][OFF_W-1:0]        kwOff,
  output logic [KW_SETS-1:0]                   kwEn
);
  localparam int LLID_IW   = $clog2(LLID_N);
  localparam int MODE_ADDR = 8'h40;
  localparam int KW_BASE   = 8'h50;
  localparam int KW_STRIDE = 8;
  localparam int KW_W      = KW_BYTES * 8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tabValid <= '0;
      tabLlid  <= '0;
      modeReg  <= MODE_LLID;
      kwVal    <= '0;
      kwMask   <= '0;
      kwOff    <= '0;
      kwEn     <= '0;
    end else if (cfgWe) begin
      if (cfgAddr < 8'(LLID_N)) begin
        tabValid[cfgAddr[LLID_IW-1:0]] <= cfgData[15];
        tabLlid[cfgAddr[LLID_IW-1:0]]  <= cfgData[LLID_W-1:0];
      end
      if (cfgAddr == 8'(MODE_ADDR)) modeReg <= pfMode_e'(cfgData[1:0]);
      for (int k = 0; k < KW_SETS; k++) begin
        if (cfgAddr == 8'(KW_BASE + k*KW_STRIDE))     kwVal[k][31:0]       <= cfgData;
        if (cfgAddr == 8'(KW_BASE + k*KW_STRIDE + 1)) kwVal[k][KW_W-1:32]  <= cfgData[KW_W-33:0];
        if (cfgAddr == 8'(KW_BASE + k*KW_STRIDE + 2)) kwMask[k][31:0]      <= cfgData;
        if (cfgAddr == 8'(KW_BASE + k*KW_STRIDE + 3)) kwMask[k][KW_W-1:32] <= cfgData[KW_W-33:0];
        if (cfgAddr == 8'(KW_BASE + k*KW_STRIDE + 4)) begin
          kwEn[k]  <= cfgData[8];
          kwOff[k] <= cfgData[OFF_W-1:0];
        end
      end
    end
  end

  // R9
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == 8'(MODE_ADDR)) |=> (modeReg == pfMode_e'($past(cfgData[1:0]))));
endmodule

// File: rtl/pff_control.sv
module pff_control
  import pf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSof,
  input  logic      inEof,
  output pfStrobe_t stb
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] curIdx;

  always_comb begin
    curIdx      = inSof ? '0 : idxReg;
    stb.beat    = inValid;
    stb.first   = inValid && inSof;
    stb.last    = inValid && inEof;
    stb.idx     = curIdx;
    stb.capLlid = inValid && (curIdx == IDX_W'(LLID_HI) || curIdx == IDX_W'(LLID_LO));
    stb.capType = inValid && (curIdx == IDX_W'(TYPE_LO - 1) || curIdx == IDX_W'(TYPE_LO));
    stb.capOp   = inValid && (curIdx == IDX_W'(OP_LO - 1) || curIdx == IDX_W'(OP_LO));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= '0;
    else if (inValid) idxReg <= (curIdx == IDX_MAX) ? curIdx : curIdx + 1'b1;
  end
endmodule

// File: rtl/pff_datapath.sv
module pff_datapath
  import pf_pkg::*;
#(
  parameter int LLID_N   = 64,
  parameter int KW_SETS  = 2,
  parameter int KW_BYTES = 6,
  parameter int WIN      = 64,
  parameter int OFF_W    = 6
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  pfStrobe_t                            stb,
  input  logic [7:0]                           inByte,
  input  logic [LLID_N-1:0]                    tabValid,
  input  logic [LLID_N-1:0][LLID_W-1:0]        tabLlid,
  input  pfMode_e                              modeReg,
  input  logic [KW_SETS-1:0][KW_BYTES*8-1:0]   kwVal,
  input  logic [KW_SETS-1:0][KW_BYTES*8-1:0]   kwMask,
  input  logic [KW_SETS-1:0][OFF_W-1:0]        kwOff,
  input  logic [KW_SETS-1:0]                   kwEn,
  output logic                                 outValid,
  output logic                                 outSof,
  output logic                                 outEof,
  output logic [7:0]                           outByte,
  output logic                                 outKeep
);
  localparam int POS_W   = $clog2(KW_BYTES);
  localparam int OFF_MAX = WIN - KW_BYTES;

  logic [15:0] llidReg, typeReg, opReg;
  logic [15:0] llidN, typeN, opN;
  logic [LLID_N-1:0] hitVec;
  logic [KW_SETS-1:0] kwHitN;
  logic typeOk, opOk, isCtl, isReg, llidHit, kwAny, userPass, keepN;

  assign llidN = stb.capLlid ? {llidReg[7:0], inByte} : llidReg;
  assign typeN = stb.capType ? {typeReg[7:0], inByte} : typeReg;
  assign opN   = stb.capOp   ? {opReg[7:0], inByte}   : opReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      llidReg <= '0;
      typeReg <= '0;
      opReg   <= '0;
    end else if (stb.beat) begin
      llidReg <= llidN;
      typeReg <= typeN;
      opReg   <= opN;
    end
  end

  for (genvar i = 0; i < LLID_N; i++) begin : g_llid
    assign hitVec[i] = tabValid[i] && (tabLlid[i] == llidN[LLID_W-1:0]);
  end

  for (genvar k = 0; k < KW_SETS; k++) begin : g_kw
    logic [IDX_W-1:0] rel;
    logic [POS_W-1:0] pos;
    logic inWin, mism, bad, seen, badN, seenN, usable;
    assign rel    = stb.idx - IDX_W'(kwOff[k]);
    assign pos    = rel[POS_W-1:0];
    assign inWin  = stb.beat && (stb.idx >= IDX_W'(kwOff[k])) && (rel < IDX_W'(KW_BYTES));
    assign mism   = |((inByte ^ kwVal[k][{pos, 3'b000} +: 8]) & kwMask[k][{pos, 3'b000} +: 8]);
    assign badN   = (stb.first ? 1'b0 : bad)  | (inWin && mism);
    assign seenN  = (stb.first ? 1'b0 : seen) | (inWin && rel == IDX_W'(KW_BYTES - 1));
    assign usable = kwEn[k] && (kwOff[k] <= OFF_W'(OFF_MAX));
    assign kwHitN[k] = usable && seenN && !badN;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bad  <= 1'b0;
        seen <= 1'b0;
      end else if (stb.beat) begin
        bad  <= badN;
        seen <= seenN;
      end
    end
  end

  always_comb begin
    typeOk  = stb.idx >= IDX_W'(TYPE_LO);
    opOk    = stb.idx >= IDX_W'(OP_LO);
    isCtl   = typeOk && (typeN == TYPE_CTL || typeN == TYPE_OAM);
    isReg   = isCtl && (typeN == TYPE_CTL) && opOk &&
              (opN == 16'h0004 || opN == 16'h0005 || opN == 16'h0006 ||
               (opN == 16'h0002 && llidN[LLID_W-1:0] == LLID_BCAST));
    llidHit = |hitVec;
    kwAny   = |kwHitN;
    case (modeReg)
      MODE_LLID: userPass = llidHit;
      MODE_KW:   userPass = kwAny;
      MODE_AND:  userPass = llidHit && kwAny;
      default:   userPass = llidHit || kwAny;
    endcase
    keepN = isCtl && (isReg || userPass);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
      outByte  <= '0;
      outKeep  <= 1'b0;
    end else begin
      outValid <= stb.beat;
      outSof   <= stb.first;
      outEof   <= stb.last;
      outByte  <= inByte;
      outKeep  <= stb.last && keepN;
    end
  end

  // R8
  keep_only_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    outKeep |-> (outEof && outValid));
  // R8
  beat_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.beat |=> outValid);
  // R1
  nonctl_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.last && !isCtl) |=> !outKeep);
  // R2
  reg_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.last && isReg) |=> outKeep);
  // R4
  empty_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.last && tabValid == '0 && modeReg == MODE_LLID && !isReg) |=> !outKeep);
endmodule

// File: rtl/pon_frame_filter.sv
module pon_frame_filter
  import pf_pkg::*;
#(
  parameter int LLID_N   = 64,
  parameter int KW_SETS  = 2,
  parameter int KW_BYTES = 6,
  parameter int WIN      = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [7:0]  inByte,
  input  logic        cfgWe,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgData,
  output logic        outValid,
  output logic        outSof,
  output logic        outEof,
  output logic [7:0]  outByte,
  output logic        outKeep
);
  localparam int OFF_W = $clog2(WIN);

  pfStrobe_t stb;
  logic [LLID_N-1:0]                  tabValid;
  logic [LLID_N-1:0][LLID_W-1:0]      tabLlid;
  pfMode_e                            modeReg;
  logic [KW_SETS-1:0][KW_BYTES*8-1:0] kwVal, kwMask;
  logic [KW_SETS-1:0][OFF_W-1:0]      kwOff;
  logic [KW_SETS-1:0]                 kwEn;

  pff_cfg_regs #(.LLID_N(LLID_N), .KW_SETS(KW_SETS), .KW_BYTES(KW_BYTES), .OFF_W(OFF_W)) cfg_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tabValid(tabValid), .tabLlid(tabLlid), .modeReg(modeReg),
    .kwVal(kwVal), .kwMask(kwMask), .kwOff(kwOff), .kwEn(kwEn));

  pff_control ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof), .stb(stb));

  pff_datapath #(.LLID_N(LLID_N), .KW_SETS(KW_SETS), .KW_BYTES(KW_BYTES), .WIN(WIN), .OFF_W(OFF_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inByte(inByte),
    .tabValid(tabValid), .tabLlid(tabLlid), .modeReg(modeReg),
    .kwVal(kwVal), .kwMask(kwMask), .kwOff(kwOff), .kwEn(kwEn),
    .outValid(outValid), .outSof(outSof), .outEof(outEof), .outByte(outByte), .outKeep(outKeep));
endmodule

// File: tb/pon_frame_filter_tb_top.sv
module pon_frame_filter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inByte = '0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic outValid, outSof, outEof, outKeep;
  logic [7:0] outByte;

  always #2 clk = ~clk;

  pon_frame_filter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof), .inByte(inByte),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outSof(outSof), .outEof(outEof), .outByte(outByte), .outKeep(outKeep));

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0, gapsOn = 0, streamBad = 0;
  bit [7:0] fb [128];
  int fLen;
  bit        mValid [64];
  bit [14:0] mLlid  [64];
  bit [1:0]  mMode;
  bit [47:0] mVal [2], mMask [2];
  bit [5:0]  mOff [2];
  bit        mEn [2];
  bit expQ[$];
  string tagQ[$];
  bit [7:0] byteQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model();
    bit [15:0] typ, op;
    bit [14:0] l15;
    bit lh, kh, ok;
    if (fLen < 22) return 1'b0;
    typ = {fb[20], fb[21]};
    if (typ != 16'h8808 && typ != 16'h8809) return 1'b0;
    l15 = {fb[6][6:0], fb[7]};
    if (typ == 16'h8808 && fLen >= 24) begin
      op = {fb[22], fb[23]};
      if (op == 4 || op == 5 || op == 6 || (op == 2 && l15 == 15'h7FFF)) return 1'b1;
    end
    lh = 0;
    for (int i = 0; i < 64; i++) if (mValid[i] && mLlid[i] == l15) lh = 1;
    kh = 0;
    for (int k = 0; k < 2; k++) begin
      if (mEn[k] && mOff[k] <= 58 && int'(mOff[k]) + 6 <= fLen) begin
        ok = 1;
        for (int j = 0; j < 6; j++)
          if (((fb[int'(mOff[k]) + j] ^ mVal[k][8*j +: 8]) & mMask[k][8*j +: 8]) != 0) ok = 0;
        if (ok) kh = 1;
      end
    end
    case (mMode)
      2'd0: return lh;
      2'd1: return kh;
      2'd2: return lh && kh;
      default: return lh || kh;
    endcase
  endfunction

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setLlid(input int i, input bit v, input bit [14:0] l);
    mValid[i] = v; mLlid[i] = l;
    cfgWrite(8'(i), {16'h0, v, l});
  endtask

  task automatic setMode(input bit [1:0] m);
    mMode = m;
    cfgWrite(8'h40, {30'h0, m});
  endtask

  task automatic setKw(input int k, input bit [47:0] v, input bit [47:0] m, input bit [5:0] off, input bit en);
    logic [7:0] b;
    mVal[k] = v; mMask[k] = m; mOff[k] = off; mEn[k] = en;
    b = 8'(8'h50 + 8*k);
    cfgWrite(b,     v[31:0]);
    cfgWrite(b + 1, {16'h0, v[47:32]});
    cfgWrite(b + 2, m[31:0]);
    cfgWrite(b + 3, {16'h0, m[47:32]});
    cfgWrite(b + 4, {23'h0, en, 2'b00, off});
  endtask

  task automatic mkFrame(input int len, input bit [15:0] typ, input bit [15:0] op, input bit [15:0] lf);
    fLen = len;
    for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
    {fb[6], fb[7]} = lf;
    {fb[20], fb[21]} = typ;
    {fb[22], fb[23]} = op;
  endtask

  task automatic putKw(input int off, input bit [47:0] v);
    for (int j = 0; j < 6; j++) fb[off + j] = v[8*j +: 8];
  endtask

  task automatic sendFrame(input string tag, input bit exp);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int j = 0; j < fLen; j++) begin
      if (gapsOn && ($urandom % 4 == 0)) begin
        @(negedge clk);
        inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inSof = (j == 0); inEof = (j == fLen - 1); inByte = fb[j];
      byteQ.push_back(fb[j]);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outKeep && !(outValid && outEof)) streamBad = 1;
      if (outValid) begin
        if (byteQ.size() == 0) streamBad = 1;
        else if (byteQ.pop_front() != outByte) streamBad = 1;
        if (outEof) begin
          if (expQ.size() == 0) check(1'b0, "R8 unexpected frame end", 1, 0);
          else begin
            bit e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(outKeep == e, t, int'(outKeep), int'(e));
          end
          check(!streamBad, "R8 stream bytes and keep placement", int'(streamBad), 0);
          streamBad = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      check(1'b0, "watchdog expired", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam bit [47:0] KW_A = 48'h665544332211;
  localparam bit [47:0] KW_B = 48'hA1B2C3D4E5F6;
  localparam bit [47:0] FULL = '1;

  initial begin
    void'($urandom(32'd20417));
    for (int i = 0; i < 64; i++) begin mValid[i] = 0; mLlid[i] = '0; end
    mMode = 0;
    for (int k = 0; k < 2; k++) begin mVal[k] = '0; mMask[k] = '0; mOff[k] = '0; mEn[k] = 0; end

    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 reset outValid", int'(outValid), 0);
    check(outKeep == 1'b0, "R9 reset outKeep", int'(outKeep), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 / R9: reset table empty, mode 0
    mkFrame(40, 16'h8809, 16'h0000, 16'h0005); sendFrame("R4 empty table after reset", 1'b0);
    // R2 registration bypass
    mkFrame(40, 16'h8808, 16'h0004, 16'h0123); sendFrame("R2 opcode 4 bypass", 1'b1);
    mkFrame(40, 16'h8808, 16'h0006, 16'h0123); sendFrame("R2 opcode 6 bypass", 1'b1);
    mkFrame(40, 16'h8808, 16'h0005, 16'h8123); sendFrame("R2 opcode 5 flag set", 1'b1);
    mkFrame(40, 16'h8808, 16'h0002, 16'h7FFF); sendFrame("R2 broadcast gate", 1'b1);
    mkFrame(40, 16'h8808, 16'h0002, 16'h0001); sendFrame("R2 unicast gate not bypassed", 1'b0);
    mkFrame(40, 16'h8809, 16'h0004, 16'h0123); sendFrame("R2 maintenance no bypass", 1'b0);
    // R3 identifier table, last entry
    setLlid(63, 1'b1, 15'h1234);
    mkFrame(40, 16'h8809, 16'h0000, 16'h1234); sendFrame("R3 entry 63 match", 1'b1);
    mkFrame(40, 16'h8809, 16'h0000, 16'h9234); sendFrame("R3 flag bit ignored", 1'b1);
    mkFrame(40, 16'h8809, 16'h0000, 16'h1235); sendFrame("R3 no match", 1'b0);
    // R1 type and length
    mkFrame(40, 16'h0800, 16'h0000, 16'h1234); sendFrame("R1 other type dropped", 1'b0);
    mkFrame(21, 16'h8808, 16'h0000, 16'h1234); sendFrame("R1 21-byte frame dropped", 1'b0);
    mkFrame(22, 16'h8808, 16'h0000, 16'h1234); sendFrame("R1 22-byte frame passes", 1'b1);
    // R4 invalidated entry
    setLlid(63, 1'b0, 15'h1234);
    mkFrame(40, 16'h8809, 16'h0000, 16'h1234); sendFrame("R4 invalid entry", 1'b0);
    // R5 keyword with mask
    setMode(2'd1);
    setKw(0, KW_A, FULL, 6'd30, 1'b1);
    mkFrame(60, 16'h8809, 16'h0000, 16'h0001); putKw(30, KW_A); sendFrame("R5 keyword match", 1'b1);
    fb[32] ^= 8'h01; sendFrame("R5 keyword bit mismatch", 1'b0);
    setKw(0, KW_A, FULL & ~48'h010000, 6'd30, 1'b1);
    sendFrame("R5 masked bit ignored", 1'b1);
    fb[32] ^= 8'h02; sendFrame("R5 unmasked bit mismatch", 1'b0);
    // R6 window boundaries
    setKw(0, KW_A, FULL, 6'd58, 1'b1);
    mkFrame(64, 16'h8809, 16'h0000, 16'h0001); putKw(58, KW_A); sendFrame("R6 offset 58 fits", 1'b1);
    fLen = 63; sendFrame("R6 frame ends inside window", 1'b0);
    setKw(0, KW_A, FULL, 6'd59, 1'b1);
    mkFrame(70, 16'h8809, 16'h0000, 16'h0001); putKw(59, KW_A); sendFrame("R6 offset 59 never", 1'b0);
    // R7 modes
    setKw(0, KW_A, FULL, 6'd30, 1'b1);
    setLlid(0, 1'b1, 15'h0042);
    setMode(2'd2);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0042); putKw(30, KW_A); sendFrame("R7 AND both", 1'b1);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0042); sendFrame("R7 AND identifier only", 1'b0);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); putKw(30, KW_A); sendFrame("R7 AND keyword only", 1'b0);
    setMode(2'd3);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0042); sendFrame("R7 OR identifier only", 1'b1);
    mkFrame(50, 16'h8808, 16'h0000, 16'h0043); putKw(30, KW_A); sendFrame("R7 OR keyword only", 1'b1);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); sendFrame("R7 OR neither", 1'b0);
    setMode(2'd0);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); putKw(30, KW_A); sendFrame("R7 identifier mode ignores keyword", 1'b0);
    // R5 second set, disabled set
    setMode(2'd1);
    setKw(0, KW_A, FULL, 6'd30, 1'b0);
    setKw(1, KW_B, FULL, 6'd10, 1'b1);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); putKw(10, KW_B); sendFrame("R5 second set match", 1'b1);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); putKw(30, KW_A); sendFrame("R5 disabled set", 1'b0);
    // R9 unmapped writes
    cfgWrite(8'h47, 32'hFFFF_FFFF);
    cfgWrite(8'h5F, 32'hFFFF_FFFF);
    cfgWrite(8'h80, 32'hFFFF_FFFF);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); sendFrame("R9 unmapped write no effect", 1'b0);
    mkFrame(50, 16'h8809, 16'h0000, 16'h0043); putKw(10, KW_B); sendFrame("R9 config kept after unmapped write", 1'b1);

    // Random phase
    gapsOn = 1;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 64; i++) setLlid(i, ($urandom % 4) == 0, 15'($urandom % 16));
      setMode(2'($urandom));
      for (int k = 0; k < 2; k++)
        setKw(k, {16'($urandom), 32'($urandom)},
              ~({16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)}),
              6'($urandom), ($urandom % 4) != 0);
      for (int f = 0; f < 50; f++) begin
        bit [15:0] typ, lf;
        int len, k;
        len = 18 + int'($urandom % 73);
        case ($urandom % 4)
          0: typ = 16'h0800;
          1: typ = 16'h8809;
          default: typ = 16'h8808;
        endcase
        lf = (($urandom % 8) == 0) ? 16'hFFFF : {1'($urandom), 15'($urandom % 32)};
        mkFrame(len, typ, 16'($urandom % 8), lf);
        if ($urandom % 2 == 1) begin
          k = int'($urandom % 2);
          if (int'(mOff[k]) + 6 <= len) putKw(int'(mOff[k]), mVal[k]);
        end
        sendFrame("R7 random frame", model());
      end
    end

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R8 all decisions delivered", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule